// File: doc/BRIEF.md
# String Descriptor Byte Server

The block keeps two banks of host-programmed text, one holding a manufacturer name and one holding a product name. Each bank has its own length register. A configuration agent loads the banks and lengths over a byte-wide register port with an address, write data, a write strobe, a read strobe and registered read data. The text is meant to be UTF-16LE code units, low byte first. The block does not check the encoding. It returns the bytes exactly as stored.

When the device side asks for a string, it presents a string index on a valid/ready request port. Index 3 selects the manufacturer bank and index 2 selects the product bank. A bank with a length of zero is never used. An accepted request freezes the selected bank and its clamped length, then streams the body one byte per cycle under consumer backpressure, with last marking the final byte. A request that cannot be served raises a one-cycle flag and streams nothing. Descriptor headers and endpoint transfer logic belong to the neighbouring logic.

Top module: `strDescServer`

## Requirements
- R1: After reset, every bank byte and both length registers read back 00h. reqReady is 1, and outValid and notServed are 0.
- R2: Manufacturer bytes live at 50h..8Fh and product bytes at 90h..CFh. Byte n of a bank sits at base+n. A write takes effect at the clock edge where regWrEn is 1. A read strobed on one edge presents the value on regRdData after that edge.
- R3: The manufacturer length register is at 40h and the product length register is at 41h. Both are 8 bits wide, read/write, and read back unmodified, including values above 64.
- R4: A request accepted with reqIndex 3 streams the manufacturer bank, and with reqIndex 2 the product bank. Bytes are presented unchanged, starting at byte 0 and ascending by one per transfer.
- R5: An accepted request whose length is L (1..64) produces exactly L transfers, with outValid high from the cycle after acceptance until the transfer that has outLast set. outLast is 1 only on transfer L-1. outValid is 0 in the cycle after that transfer.
- R6: A length above 64 is treated as 64, so the stream never goes past the last byte of its bank.
- R7: A request accepted with any index other than 2 or 3, or with the selected length equal to 0, sets notServed for exactly the one cycle after acceptance. No byte is streamed.
- R8: While outValid is 1 and outReady is 0, outValid, outData and outLast hold their values.
- R9: Bank contents and length are captured when a request is accepted. Register writes during a stream do not change that stream but apply to later requests.
- R10: reqReady is 1 only when no stream is active. A request presented during a stream is ignored: it neither interrupts the stream nor raises notServed.
- R11: Addresses outside 40h..41h and 50h..CFh read 00h, and writes to them leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 8 | Registered read data |
| reqValid | input | 1 | String request present |
| reqIndex | input | 8 | Requested string index |
| reqReady | output | 1 | Request can be accepted |
| outReady | input | 1 | Consumer takes the current byte |
| outValid | output | 1 | Stream byte present |
| outData | output | 8 | Stream byte |
| outLast | output | 1 | Current byte is the final one |
| notServed | output | 1 | One-cycle flag: request had no bank to serve it |

## Verification
The assertions assume the consumer follows the valid/ready rules. They also assume that outReady, reqValid and the register strobes are known values whenever reset is released. The bench drives every input from tasks at the falling edge, so these inputs are always defined. It produces the three outReady patterns (always high, two-in-three, alternating) arithmetically from a cycle count. The hold and ordering properties therefore see real stalls. They never see a consumer that drops a byte.

// File: rtl/strdesc_pkg.sv
package strdesc_pkg;

  typedef struct packed {
    logic loadSnap;
    logic selProd;
  } ctrlStrobe_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_STREAM = 1'b1
  } srvState_e;

endpackage

// File: rtl/strdesc_regbank.sv
module strdesc_regbank
  import strdesc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LEN_W = 8,
  parameter int DEPTH = 64,
  parameter logic [ADDR_W-1:0] MFG_BASE = 8'h50,
  parameter logic [ADDR_W-1:0] PROD_BASE = 8'h90,
  parameter logic [ADDR_W-1:0] MFG_LEN_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] PROD_LEN_ADDR = 8'h41,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  output logic [LEN_W-1:0]  mfgLen,
  output logic [LEN_W-1:0]  prodLen,
  input  ctrlStrobe_t       strobe,
  input  logic [PTR_W-1:0]  rdPtr,
  output logic [DATA_W-1:0] streamByte
);

  logic [DATA_W-1:0] mfgMem  [DEPTH];
  logic [DATA_W-1:0] prodMem [DEPTH];
  logic [DATA_W-1:0] snapMem [DEPTH];
  logic [DATA_W-1:0] rdMux;

  // host-side storage: banks and length registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        mfgMem[i]  <= '0;
        prodMem[i] <= '0;
      end
      mfgLen  <= '0;
      prodLen <= '0;
    end else if (regWrEn) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (regAddr == MFG_BASE + ADDR_W'(i))  mfgMem[i]  <= regWrData;
        if (regAddr == PROD_BASE + ADDR_W'(i)) prodMem[i] <= regWrData;
      end
      if (regAddr == MFG_LEN_ADDR)  mfgLen  <= LEN_W'(regWrData);
      if (regAddr == PROD_LEN_ADDR) prodLen <= LEN_W'(regWrData);
    end
  end

  // frozen copy of the selected bank, loaded on request acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) snapMem[i] <= '0;
    end else if (strobe.loadSnap) begin
      for (int i = 0; i < DEPTH; i++)
        snapMem[i] <= strobe.selProd ? prodMem[i] : mfgMem[i];
    end
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (regAddr == MFG_BASE + ADDR_W'(i))  rdMux = mfgMem[i];
      if (regAddr == PROD_BASE + ADDR_W'(i)) rdMux = prodMem[i];
    end
    if (regAddr == MFG_LEN_ADDR)  rdMux = DATA_W'(mfgLen);
    if (regAddr == PROD_LEN_ADDR) rdMux = DATA_W'(prodLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end

  assign streamByte = snapMem[rdPtr];

  // R9: without a new snapshot, a fixed pointer sees a fixed byte
  a_r9_snap_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadSnap |=> ($stable(rdPtr) |-> $stable(streamByte)));

endmodule

// File: rtl/strdesc_ctrl.sv
module strdesc_ctrl
  import strdesc_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int IDX_W = 8,
  parameter int DEPTH = 64,
  parameter logic [IDX_W-1:0] MFG_INDEX = 8'd3,
  parameter logic [IDX_W-1:0] PROD_INDEX = 8'd2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] reqIndex,
  output logic             reqReady,
  input  logic [LEN_W-1:0] mfgLen,
  input  logic [LEN_W-1:0] prodLen,
  input  logic             outReady,
  output logic             outValid,
  output logic             outLast,
  output logic             notServed,
  output ctrlStrobe_t      strobe,
  output logic [PTR_W-1:0] rdPtr
);

  srvState_e        state;
  logic [CNT_W-1:0] lenCap;
  logic [PTR_W-1:0] ptr;
  logic             accept;
  logic             hitMfg;
  logic             hitProd;
  logic             startRun;
  logic [CNT_W-1:0] pickLen;

  function automatic logic [CNT_W-1:0] clampLen(input logic [LEN_W-1:0] l);
    if (l > LEN_W'(DEPTH)) return CNT_W'(DEPTH);
    return CNT_W'(l);
  endfunction

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign hitMfg   = (reqIndex == MFG_INDEX) && (mfgLen != '0);
  assign hitProd  = (reqIndex == PROD_INDEX) && (prodLen != '0);
  assign startRun = accept && (hitMfg || hitProd);
  assign pickLen  = hitProd ? clampLen(prodLen) : clampLen(mfgLen);

  assign strobe.loadSnap = startRun;
  assign strobe.selProd  = hitProd;

  assign outValid = (state == ST_STREAM);
  assign outLast  = outValid && ({1'b0, ptr} == lenCap - CNT_W'(1));
  assign rdPtr    = ptr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      lenCap    <= '0;
      ptr       <= '0;
      notServed <= 1'b0;
    end else begin
      notServed <= accept && !startRun;
      case (state)
        ST_IDLE: begin
          if (startRun) begin
            state  <= ST_STREAM;
            lenCap <= pickLen;
            ptr    <= '0;
          end
        end
        ST_STREAM: begin
          if (outReady) begin
            if (outLast) state <= ST_IDLE;
            else         ptr   <= ptr + PTR_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: pointer stays below the captured length, which never exceeds the bank
  a_r6_ptr_in_bank: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (({1'b0, ptr} < lenCap) && (lenCap <= CNT_W'(DEPTH))));

  // R8: a stalled beat keeps its position and last flag
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(ptr) && $stable(outLast)));

  // R5: the stream ends right after the last beat is taken
  a_r5_end_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> !outValid);

  // R10: a stream is never abandoned before its last beat
  a_r10_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !(outReady && outLast)) |=> (outValid && !notServed));

  // R7: the refusal flag never coincides with a stream
  a_r7_flag_alone: assert property (@(posedge clk) disable iff (!rstN)
    notServed |-> !outValid);

endmodule

// File: rtl/strDescServer.sv
module strDescServer
  import strdesc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LEN_W = 8,
  parameter int IDX_W = 8,
  parameter int DEPTH = 64,
  parameter logic [ADDR_W-1:0] MFG_BASE = 8'h50,
  parameter logic [ADDR_W-1:0] PROD_BASE = 8'h90,
  parameter logic [ADDR_W-1:0] MFG_LEN_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] PROD_LEN_ADDR = 8'h41,
  parameter logic [IDX_W-1:0] MFG_INDEX = 8'd3,
  parameter logic [IDX_W-1:0] PROD_INDEX = 8'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  reqIndex,
  output logic              reqReady,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              notServed
);

  localparam int PTR_W = $clog2(DEPTH);

  ctrlStrobe_t      strobe;
  logic [PTR_W-1:0] rdPtr;
  logic [LEN_W-1:0] mfgLen;
  logic [LEN_W-1:0] prodLen;

  strdesc_regbank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH),
    .MFG_BASE(MFG_BASE), .PROD_BASE(PROD_BASE),
    .MFG_LEN_ADDR(MFG_LEN_ADDR), .PROD_LEN_ADDR(PROD_LEN_ADDR)
  ) u_bank (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regRdData(regRdData),
    .mfgLen(mfgLen), .prodLen(prodLen),
    .strobe(strobe), .rdPtr(rdPtr), .streamByte(outData)
  );

  strdesc_ctrl #(
    .LEN_W(LEN_W), .IDX_W(IDX_W), .DEPTH(DEPTH),
    .MFG_INDEX(MFG_INDEX), .PROD_INDEX(PROD_INDEX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqIndex(reqIndex), .reqReady(reqReady),
    .mfgLen(mfgLen), .prodLen(prodLen),
    .outReady(outReady), .outValid(outValid), .outLast(outLast),
    .notServed(notServed), .strobe(strobe), .rdPtr(rdPtr)
  );

  // R8: stalled data byte holds across the stall
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

endmodule

// File: tb/sim_strDescServer.sv
module sim_strDescServer;

  localparam logic [7:0] MFG_BASE  = 8'h50;
  localparam logic [7:0] PROD_BASE = 8'h90;
  localparam logic [7:0] MFG_LEN   = 8'h40;
  localparam logic [7:0] PROD_LEN  = 8'h41;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0;
  logic [7:0] regAddr = '0, regWrData = '0, regRdData;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic       reqValid = 1'b0, reqReady;
  logic [7:0] reqIndex = '0;
  logic       outReady = 1'b1, outValid, outLast, notServed;
  logic [7:0] outData;

  int nChk = 0, nFail = 0;
  logic [7:0] mfgModel [64];
  logic [7:0] prodModel[64];
  logic [7:0] mfgLenM = '0, prodLenM = '0;

  strDescServer u0 (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regRdData(regRdData),
    .reqValid(reqValid), .reqIndex(reqIndex), .reqReady(reqReady),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .outLast(outLast), .notServed(notServed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b, input int i, input int seed);
    return 8'(i * 13 + b * 101 + seed * 7 + 5);
  endfunction

  function automatic int clampM(input logic [7:0] l);
    return (l > 8'd64) ? 64 : int'(l);
  endfunction

  function automatic bit rdyFor(input int mode, input int c);
    if (mode == 1) return (c % 3) != 1;
    if (mode == 2) return (c % 2) == 0;
    return 1'b1;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic runReq(input logic [7:0] idx, input int mode, input bit disturb);
    logic [7:0] expArr[64];
    int expLen, k, cyc;
    bit done;
    for (int i = 0; i < 64; i++) expArr[i] = (idx == 8'd2) ? prodModel[i] : mfgModel[i];
    expLen = (idx == 8'd3) ? clampM(mfgLenM) : (idx == 8'd2) ? clampM(prodLenM) : 0;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10 ready when idle", reqReady, 1);
    reqValid = 1'b1; reqIndex = idx;
    @(negedge clk);
    reqValid = 1'b0;
    if (expLen == 0) begin
      chk(notServed == 1'b1 && outValid == 1'b0, "R7 refusal flag", {notServed, outValid}, 2);
      @(negedge clk);
      chk(notServed == 1'b0 && outValid == 1'b0, "R7 one cycle, no bytes", {notServed, outValid}, 0);
      return;
    end
    chk(notServed == 1'b0, "R7 no flag on served request", notServed, 0);
    k = 0; cyc = 0; done = 1'b0;
    while (!done && cyc < 400) begin
      outReady = rdyFor(mode, cyc);
      chk(outValid == 1'b1, "R5 valid through stream", outValid, 1);
      chk(outData == expArr[k], (expLen == 64) ? "R6 byte order" : "R4 byte order", outData, expArr[k]);
      chk(outLast == (k == expLen - 1), "R5 last flag", outLast, (k == expLen - 1));
      if (disturb) begin
        chk(notServed == 1'b0, "R10 busy request ignored", notServed, 0);
        reqValid = (cyc == 1);
        reqIndex = 8'd2;
        regWrEn  = (cyc == 2) || (cyc == 3);
        regAddr  = (cyc == 2) ? MFG_BASE + 8'd1 : MFG_LEN;
        regWrData = (cyc == 2) ? ~expArr[1] : 8'd2;
        if (cyc == 1) chk(reqReady == 1'b0, "R10 not ready while busy", reqReady, 0);
      end
      if (outReady && outValid) begin
        if (k == expLen - 1) done = 1'b1;
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    regWrEn = 1'b0; reqValid = 1'b0; outReady = 1'b1;
    chk(outValid == 1'b0 && k == expLen, (expLen == 64) ? "R6 byte count" : "R5 byte count", k, expLen);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 64; i++) begin mfgModel[i] = '0; prodModel[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(reqReady == 1'b1 && outValid == 1'b0 && notServed == 1'b0, "R1 reset outputs",
        {reqReady, outValid, notServed}, 4);
    for (int i = 0; i < 64; i++) begin
      rd(MFG_BASE + 8'(i), v);  chk(v == 8'h00, "R1 mfg byte reset", v, 0);
      rd(PROD_BASE + 8'(i), v); chk(v == 8'h00, "R1 prod byte reset", v, 0);
    end
    rd(MFG_LEN, v);  chk(v == 8'h00, "R1 mfg length reset", v, 0);
    rd(PROD_LEN, v); chk(v == 8'h00, "R1 prod length reset", v, 0);

    // R2 bank write and readback
    for (int i = 0; i < 64; i++) begin
      mfgModel[i] = pat(0, i, 1);  wr(MFG_BASE + 8'(i), mfgModel[i]);
      prodModel[i] = pat(1, i, 1); wr(PROD_BASE + 8'(i), prodModel[i]);
    end
    for (int i = 0; i < 64; i++) begin
      rd(MFG_BASE + 8'(i), v);  chk(v == mfgModel[i], "R2 mfg readback", v, mfgModel[i]);
      rd(PROD_BASE + 8'(i), v); chk(v == prodModel[i], "R2 prod readback", v, prodModel[i]);
    end

    // R3 length registers
    wr(MFG_LEN, 8'hC3); wr(PROD_LEN, 8'h3C);
    rd(MFG_LEN, v);  chk(v == 8'hC3, "R3 mfg length", v, 8'hC3);
    rd(PROD_LEN, v); chk(v == 8'h3C, "R3 prod length", v, 8'h3C);
    wr(MFG_LEN, 8'h00); wr(PROD_LEN, 8'h00);

    // R11 unmapped addresses
    for (int a = 0; a < 256; a++) begin
      if (!((a >= 8'h40 && a <= 8'h41) || (a >= 8'h50 && a <= 8'hCF))) begin
        wr(8'(a), 8'hA5);
        rd(8'(a), v);
        chk(v == 8'h00, "R11 unmapped reads zero", v, 0);
      end
    end
    for (int i = 0; i < 64; i++) begin
      rd(MFG_BASE + 8'(i), v);  chk(v == mfgModel[i], "R11 mfg untouched", v, mfgModel[i]);
      rd(PROD_BASE + 8'(i), v); chk(v == prodModel[i], "R11 prod untouched", v, prodModel[i]);
    end
    rd(MFG_LEN, v); chk(v == 8'h00, "R11 length untouched", v, 0);

    // R4 R5 R6 R7 R8: length sweep on both banks with three stall patterns
    for (int n = 0; n < 69; n++) begin
      logic [7:0] len;
      len = (n < 67) ? 8'(n) : (n == 67) ? 8'd100 : 8'd255;
      mfgLenM = len;  wr(MFG_LEN, len);
      runReq(8'd3, n % 3, 1'b0);
      prodLenM = len; wr(PROD_LEN, len);
      runReq(8'd2, (n + 1) % 3, 1'b0);
    end

    // R7 R4: index sweep with both lengths non-zero
    mfgLenM = 8'd5;  wr(MFG_LEN, 8'd5);
    prodLenM = 8'd4; wr(PROD_LEN, 8'd4);
    for (int x = 0; x < 256; x++) runReq(8'(x), 0, 1'b0);

    // R9 R10: writes and a request during an active stream
    mfgLenM = 8'd10; wr(MFG_LEN, 8'd10);
    runReq(8'd3, 1, 1'b1);
    mfgModel[1] = ~mfgModel[1];
    mfgLenM = 8'd2;
    rd(MFG_LEN, v); chk(v == 8'd2, "R9 length write landed", v, 2);
    runReq(8'd3, 0, 1'b0);

    summary();
  end

endmodule